// File: doc/BRIEF.md
# DSP Storage Readout Engine

This block serves a host that needs to look inside a DSP over a byte-wide control link. The host sends a command byte and, for the three memory classes, two address bytes. The engine works out which storage is meant and checks that the access is allowed. It then fetches the word and streams it back as a fixed number of bytes, most significant byte first. Program words are 36 bits wide, coefficient words 20 bits and offset words 15 bits. Each class has its own byte layout.

Control and power-supply registers sit outside the block and are presented as flat input vectors. An identification command returns a constant. The three memories are modelled as synchronous-read arrays with computed contents. Both the command side and the response side move one byte per valid/ready handshake. The response side marks the final byte of each transaction and flags transactions that were refused.

Top module: `dsp_mem_readout`

## Requirements
- R1: While rst_ni is low, and after it is released, cmd_ready_o is 1 and rsp_valid_o, rsp_last_o and rsp_err_o are 0.
- R2: The modelled memory word at address a is built as follows. Let x be the 16-bit value a XOR salt, with salt 0x5A3C for program, 0xC3A5 for coefficient and 0x0F96 for offset storage. The word is the low W bits of {x, ~x, x}.
- R3: Command 0x38 reads program storage. The address is 12 bits: the low nibble of the first address byte followed by the second byte. The upper nibble of the first address byte is ignored. The reply is five bytes: {4'b0, w[35:32]}, then w[31:24], w[23:16], w[15:8] and w[7:0].
- R4: Command 0x34 reads coefficient storage. The address is 11 bits: the low 3 bits of the first address byte followed by the second byte. The upper 5 bits of the first address byte are ignored. The reply is three bytes: w[19:12], w[11:4] and {w[3:0], 4'b0}.
- R5: Command 0x32 reads an offset register. The address is the low 5 bits of the second address byte. The first address byte and the top 3 bits of the second are ignored. The reply is three bytes: 0x00, {1'b0, w[14:8]} and w[7:0].
- R6: A memory read (R3 to R5) is allowed only if dl_ready_i is 1 and dsp_run_i is 0 when the command byte is accepted. If it is refused, both address bytes are still consumed, and the reply has the normal length with every byte 0x00 and rsp_err_o high. A refused read does not disturb later reads.
- R7: Commands 0x40 to 0x47 return the single byte ctrl_regs_i[8n+7:8n], where n is the command minus 0x40. Commands 0x50 and 0x51 return pwr_regs_i[8n+7:8n], where n is the command minus 0x50. Neither is gated by dl_ready_i or dsp_run_i.
- R8: Command 0x60 returns the single byte 0x19 in either DSP state.
- R9: Any other command byte returns one byte 0x00 with rsp_err_o and rsp_last_o high, and no address bytes are consumed.
- R10: rsp_last_o is high only on the final byte of a reply. rsp_err_o is low for every byte of an allowed reply. After the final byte is accepted, cmd_ready_o is 1 again.
- R11: A single-byte reply is valid in the cycle after the command byte is accepted. A memory reply's first byte is valid two cycles after the second address byte is accepted. cmd_ready_o stays low while a reply is pending.
- R12: While rsp_valid_o is high and rsp_ready_i is low, rsp_valid_o, rsp_data_o and rsp_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dl_ready_i | input | 1 | Download-ready flag; must be 1 for memory reads |
| dsp_run_i | input | 1 | 1 when the DSP runs, 0 when it is held in reset |
| ctrl_regs_i | input | 64 | Eight control register bytes, byte n at bits 8n+7:8n |
| pwr_regs_i | input | 16 | Two power-supply register bytes |
| cmd_valid_i | input | 1 | Command/address byte valid |
| cmd_data_i | input | 8 | Command/address byte |
| cmd_ready_o | output | 1 | Engine accepts a command/address byte |
| rsp_valid_o | output | 1 | Reply byte valid |
| rsp_ready_i | input | 1 | Host accepts the reply byte |
| rsp_data_o | output | 8 | Reply byte |
| rsp_last_o | output | 1 | Final byte of the reply |
| rsp_err_o | output | 1 | Reply belongs to a refused or unknown command |

## Verification
The properties take nothing for granted about when the host raises rsp_ready_i or cmd_valid_i. The engine drops cmd_ready_o while a reply is pending, so the host cannot interleave commands. The one assumption is that the gating flags and register inputs only matter at command acceptance. For that reason the stimulus changes dl_ready_i, dsp_run_i and the register vectors only while the engine is idle between transactions. The host side drives bytes only on the falling edge and drops valid after each handshake.

// File: rtl/dsp_rd_pkg.sv
package dsp_rd_pkg;

  localparam logic [7:0] CMD_PRAM  = 8'h38;
  localparam logic [7:0] CMD_CRAM  = 8'h34;
  localparam logic [7:0] CMD_OFR   = 8'h32;
  localparam logic [7:0] CMD_CTRL  = 8'h40;
  localparam logic [7:0] CMD_PWR   = 8'h50;
  localparam logic [7:0] CMD_ID    = 8'h60;
  localparam logic [7:0] ID_CODE   = 8'h19;

  localparam logic [15:0] PRAM_SALT = 16'h5A3C;
  localparam logic [15:0] CRAM_SALT = 16'hC3A5;
  localparam logic [15:0] OFR_SALT  = 16'h0F96;

  typedef enum logic [2:0] {
    TGT_PRAM, TGT_CRAM, TGT_OFR, TGT_CTRL, TGT_PWR, TGT_ID, TGT_BAD
  } tgt_e;

  typedef enum logic [2:0] {
    S_CMD, S_AH, S_AL, S_WAIT, S_RSP
  } st_e;

  // model content of the storage arrays
  function automatic logic [47:0] rom_pat(logic [15:0] a, logic [15:0] salt);
    logic [15:0] x;
    x = a ^ salt;
    return {x, ~x, x};
  endfunction

endpackage

// File: rtl/dsp_rd_rom.sv
module dsp_rd_rom
  import dsp_rd_pkg::*;
#(
  parameter int          AW   = 12,
  parameter int          DW   = 36,
  parameter logic [15:0] SALT = 16'h0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [15:0]   addr_i,
  output logic [DW-1:0] data_o
);
  localparam logic [15:0] AMASK = 16'((32'd1 << AW) - 1);

  logic [15:0] addr_m;
  assign addr_m = addr_i & AMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (rd_i) data_o <= DW'(rom_pat(addr_m, SALT));
  end
endmodule

// File: rtl/dsp_rd_fmt.sv
// Places a word into NB bytes (left or right justified), then at the top of the staging buffer.
module dsp_rd_fmt #(
  parameter int DW = 36,
  parameter int NB = 5,
  parameter bit LJ = 1'b0,
  parameter int BW = 40
) (
  input  logic [DW-1:0] word_i,
  output logic [BW-1:0] buf_o
);
  localparam int FW = 8 * NB;

  logic [FW-1:0] field;

  generate
    if (LJ) begin : g_left
      assign field = {word_i, {(FW-DW){1'b0}}};
    end else begin : g_right
      assign field = {{(FW-DW){1'b0}}, word_i};
    end
  endgenerate

  assign buf_o = BW'(field) << (BW - FW);
endmodule

// File: rtl/dsp_rd_decode.sv
module dsp_rd_decode
  import dsp_rd_pkg::*;
#(
  parameter int NCTRL   = 8,
  parameter int NPWR    = 2,
  parameter int PRAM_NB = 5,
  parameter int CRAM_NB = 3,
  parameter int OFR_NB  = 3,
  parameter int CNT_W   = 3
) (
  input  logic [7:0]       cmd_i,
  input  logic             dl_ready_i,
  input  logic             dsp_run_i,
  output tgt_e             tgt_o,
  output logic             need_addr_o,
  output logic             deny_o,
  output logic [CNT_W-1:0] len_o
);
  logic is_mem;

  always_comb begin
    tgt_o = TGT_BAD;
    if (cmd_i == CMD_PRAM)      tgt_o = TGT_PRAM;
    else if (cmd_i == CMD_CRAM) tgt_o = TGT_CRAM;
    else if (cmd_i == CMD_OFR)  tgt_o = TGT_OFR;
    else if (cmd_i == CMD_ID)   tgt_o = TGT_ID;
    else if (int'(cmd_i) >= int'(CMD_CTRL) && int'(cmd_i) < int'(CMD_CTRL) + NCTRL)
      tgt_o = TGT_CTRL;
    else if (int'(cmd_i) >= int'(CMD_PWR) && int'(cmd_i) < int'(CMD_PWR) + NPWR)
      tgt_o = TGT_PWR;
  end

  assign is_mem      = (tgt_o == TGT_PRAM) || (tgt_o == TGT_CRAM) || (tgt_o == TGT_OFR);
  assign need_addr_o = is_mem;
  assign deny_o      = (tgt_o == TGT_BAD) || (is_mem && !(dl_ready_i && !dsp_run_i));

  always_comb begin
    unique case (tgt_o)
      TGT_PRAM: len_o = CNT_W'(PRAM_NB);
      TGT_CRAM: len_o = CNT_W'(CRAM_NB);
      TGT_OFR:  len_o = CNT_W'(OFR_NB);
      default:  len_o = CNT_W'(1);
    endcase
  end
endmodule

// File: rtl/dsp_mem_readout.sv
module dsp_mem_readout
  import dsp_rd_pkg::*;
#(
  parameter int PRAM_AW = 12,
  parameter int PRAM_DW = 36,
  parameter int PRAM_NB = 5,
  parameter int CRAM_AW = 11,
  parameter int CRAM_DW = 20,
  parameter int CRAM_NB = 3,
  parameter int OFR_AW  = 5,
  parameter int OFR_DW  = 15,
  parameter int OFR_NB  = 3,
  parameter int NCTRL   = 8,
  parameter int NPWR    = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dl_ready_i,
  input  logic           dsp_run_i,
  input  logic [8*NCTRL-1:0] ctrl_regs_i,
  input  logic [8*NPWR-1:0]  pwr_regs_i,
  input  logic           cmd_valid_i,
  input  logic [7:0]     cmd_data_i,
  output logic           cmd_ready_o,
  output logic           rsp_valid_o,
  input  logic           rsp_ready_i,
  output logic [7:0]     rsp_data_o,
  output logic           rsp_last_o,
  output logic           rsp_err_o
);
  localparam int MAX_NB = (PRAM_NB > CRAM_NB)
                        ? ((PRAM_NB > OFR_NB) ? PRAM_NB : OFR_NB)
                        : ((CRAM_NB > OFR_NB) ? CRAM_NB : OFR_NB);
  localparam int BW    = 8 * MAX_NB;
  localparam int CNT_W = $clog2(MAX_NB + 1);
  localparam int CI_W  = (NCTRL > 1) ? $clog2(NCTRL) : 1;
  localparam int PI_W  = (NPWR > 1) ? $clog2(NPWR) : 1;

  st_e              state_q;
  tgt_e             tgt_q, tgt_d;
  logic             err_q, deny_d, need_addr_d;
  logic [CNT_W-1:0] cnt_q, len_d;
  logic [7:0]       addr_hi_q;
  logic [BW-1:0]    buf_q, mem_buf;
  logic [BW-1:0]    pr_buf, cr_buf, of_buf;
  logic [7:0]       reg_byte;
  logic             cmd_fire, rsp_fire, rd_base;
  logic [15:0]      addr16;
  logic [PRAM_DW-1:0] pr_word;
  logic [CRAM_DW-1:0] cr_word;
  logic [OFR_DW-1:0]  of_word;
  logic [CI_W-1:0]  ci;
  logic [PI_W-1:0]  pi;

  assign cmd_ready_o = (state_q == S_CMD) || (state_q == S_AH) || (state_q == S_AL);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign rsp_valid_o = (state_q == S_RSP);
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;
  assign rsp_data_o  = buf_q[BW-1 -: 8];
  assign rsp_last_o  = rsp_valid_o && (cnt_q == CNT_W'(1));
  assign rsp_err_o   = rsp_valid_o && err_q;

  dsp_rd_decode #(
    .NCTRL(NCTRL), .NPWR(NPWR), .PRAM_NB(PRAM_NB), .CRAM_NB(CRAM_NB),
    .OFR_NB(OFR_NB), .CNT_W(CNT_W)
  ) u_dec (
    .cmd_i(cmd_data_i), .dl_ready_i(dl_ready_i), .dsp_run_i(dsp_run_i),
    .tgt_o(tgt_d), .need_addr_o(need_addr_d), .deny_o(deny_d), .len_o(len_d)
  );

  // single-byte sources, picked from the command byte itself
  assign ci = CI_W'(cmd_data_i - CMD_CTRL);
  assign pi = PI_W'(cmd_data_i - CMD_PWR);
  always_comb begin
    unique case (tgt_d)
      TGT_CTRL: reg_byte = ctrl_regs_i[8*ci +: 8];
      TGT_PWR:  reg_byte = pwr_regs_i[8*pi +: 8];
      TGT_ID:   reg_byte = ID_CODE;
      default:  reg_byte = 8'h00;
    endcase
  end

  // read issued on the final address byte
  assign addr16  = {addr_hi_q, cmd_data_i};
  assign rd_base = (state_q == S_AL) && cmd_fire && !err_q;

  dsp_rd_rom #(.AW(PRAM_AW), .DW(PRAM_DW), .SALT(PRAM_SALT)) u_pram (
    .clk_i, .rst_ni, .rd_i(rd_base && tgt_q == TGT_PRAM), .addr_i(addr16), .data_o(pr_word));
  dsp_rd_rom #(.AW(CRAM_AW), .DW(CRAM_DW), .SALT(CRAM_SALT)) u_cram (
    .clk_i, .rst_ni, .rd_i(rd_base && tgt_q == TGT_CRAM), .addr_i(addr16), .data_o(cr_word));
  dsp_rd_rom #(.AW(OFR_AW), .DW(OFR_DW), .SALT(OFR_SALT)) u_ofr (
    .clk_i, .rst_ni, .rd_i(rd_base && tgt_q == TGT_OFR), .addr_i(addr16), .data_o(of_word));

  dsp_rd_fmt #(.DW(PRAM_DW), .NB(PRAM_NB), .LJ(1'b0), .BW(BW)) u_fmt_pr (.word_i(pr_word), .buf_o(pr_buf));
  dsp_rd_fmt #(.DW(CRAM_DW), .NB(CRAM_NB), .LJ(1'b1), .BW(BW)) u_fmt_cr (.word_i(cr_word), .buf_o(cr_buf));
  dsp_rd_fmt #(.DW(OFR_DW),  .NB(OFR_NB),  .LJ(1'b0), .BW(BW)) u_fmt_of (.word_i(of_word), .buf_o(of_buf));

  always_comb begin
    unique case (tgt_q)
      TGT_PRAM: mem_buf = pr_buf;
      TGT_CRAM: mem_buf = cr_buf;
      default:  mem_buf = of_buf;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_CMD;
      tgt_q     <= TGT_BAD;
      err_q     <= 1'b0;
      cnt_q     <= '0;
      addr_hi_q <= '0;
      buf_q     <= '0;
    end else begin
      unique case (state_q)
        S_CMD: if (cmd_fire) begin
          tgt_q <= tgt_d;
          err_q <= deny_d;
          cnt_q <= len_d;
          if (need_addr_d) begin
            state_q <= S_AH;
          end else begin
            buf_q   <= deny_d ? '0 : (BW'(reg_byte) << (BW - 8));
            state_q <= S_RSP;
          end
        end
        S_AH: if (cmd_fire) begin
          addr_hi_q <= cmd_data_i;
          state_q   <= S_AL;
        end
        S_AL: if (cmd_fire) state_q <= S_WAIT;
        S_WAIT: begin
          buf_q   <= err_q ? '0 : mem_buf;
          state_q <= S_RSP;
        end
        S_RSP: if (rsp_fire) begin
          buf_q <= buf_q << 8;
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= S_CMD;
        end
        default: state_q <= S_CMD;
      endcase
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o));

  p_no_overlap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && rsp_valid_o));

  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_data_o == 8'h00);

  p_last_frees_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i && rsp_last_o |=> cmd_ready_o && !rsp_valid_o);

  p_rd_wait_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_base |=> !rsp_valid_o ##1 rsp_valid_o);

  p_flags_qual_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_last_o || rsp_err_o) |-> rsp_valid_o);

endmodule

// File: tb/tb_dsp_mem_readout.sv
`timescale 1ns/1ps
module tb_dsp_mem_readout;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dl_ready_i = 1'b0, dsp_run_i = 1'b0;
  logic [63:0] ctrl_regs_i = 64'h8877_6655_4433_2211;
  logic [15:0] pwr_regs_i  = 16'hB2A1;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_data_i  = 8'h00;
  logic        cmd_ready_o, rsp_valid_o, rsp_last_o, rsp_err_o;
  logic        rsp_ready_i = 1'b0;
  logic [7:0]  rsp_data_o;

  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  dsp_mem_readout dut (.*);

  // {cmd, a1, a2, dl_ready, run, err, len}
  localparam int NV = 18;
  localparam logic [29:0] VEC [NV] = '{
    {8'h38, 8'h0F, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd5},
    {8'h38, 8'hF1, 8'h23, 1'b1, 1'b0, 1'b0, 3'd5},
    {8'h34, 8'h07, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd3},
    {8'h34, 8'hFC, 8'h01, 1'b1, 1'b0, 1'b0, 3'd3},
    {8'h32, 8'h00, 8'h1F, 1'b1, 1'b0, 1'b0, 3'd3},
    {8'h32, 8'hAB, 8'hE5, 1'b1, 1'b0, 1'b0, 3'd3},
    {8'h38, 8'h00, 8'h10, 1'b0, 1'b0, 1'b1, 3'd5},
    {8'h34, 8'h00, 8'h10, 1'b1, 1'b1, 1'b1, 3'd3},
    {8'h32, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 3'd3},
    {8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd1},
    {8'h47, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd1},
    {8'h50, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1},
    {8'h51, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd1},
    {8'h60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd1},
    {8'h60, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd1},
    {8'h33, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1},
    {8'h48, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1},
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 3'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 content model
  function automatic logic [47:0] pat(logic [15:0] a, logic [15:0] s);
    logic [15:0] x;
    x = a ^ s;
    return {x, ~x, x};
  endfunction

  function automatic logic [7:0] exp_byte(logic [7:0] cmd, logic [7:0] a1, logic [7:0] a2, int idx);
    logic [47:0] p;
    logic [39:0] v40;
    logic [23:0] v24;
    case (cmd)
      8'h38: begin p = pat({4'b0, a1[3:0], a2}, 16'h5A3C); v40 = {4'b0, p[35:0]}; return v40[8*(4-idx) +: 8]; end
      8'h34: begin p = pat({5'b0, a1[2:0], a2}, 16'hC3A5); v24 = {p[19:0], 4'b0}; return v24[8*(2-idx) +: 8]; end
      8'h32: begin p = pat({11'b0, a2[4:0]}, 16'h0F96);     v24 = {9'b0, p[14:0]}; return v24[8*(2-idx) +: 8]; end
      8'h60: return 8'h19;
      default: begin
        if (cmd >= 8'h40 && cmd <= 8'h47) return ctrl_regs_i[8*(cmd-8'h40) +: 8];
        if (cmd >= 8'h50 && cmd <= 8'h51) return pwr_regs_i[8*(cmd-8'h50) +: 8];
        return 8'h00;
      end
    endcase
  endfunction

  // called at a falling edge; returns at the falling edge after the handshake
  task automatic send(input logic [7:0] b);
    cmd_valid_i = 1'b1;
    cmd_data_i  = b;
    while (!cmd_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic recv(output logic [7:0] d, output logic l, output logic e);
    while (!rsp_valid_o) @(negedge clk_i);
    d = rsp_data_o; l = rsp_last_o; e = rsp_err_o;
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, d0;
    logic l, e;
    string tag;
    // R1: during reset and after release
    #1;
    chk(cmd_ready_o == 1'b1 && rsp_valid_o == 1'b0 && rsp_last_o == 1'b0 && rsp_err_o == 1'b0,
        "R1 in reset", {cmd_ready_o, rsp_valid_o, rsp_last_o, rsp_err_o}, 4'b1000);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1 && rsp_valid_o == 1'b0, "R1 after release",
        {cmd_ready_o, rsp_valid_o}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] cmd, a1, a2;
      logic xerr;
      int len;
      bit mem;
      {cmd, a1, a2, dl_ready_i, dsp_run_i, xerr} = VEC[i][29:3];
      len = int'(VEC[i][2:0]);
      mem = (cmd == 8'h38) || (cmd == 8'h34) || (cmd == 8'h32);
      tag = (cmd == 8'h38) ? "R3" : (cmd == 8'h34) ? "R4" : (cmd == 8'h32) ? "R5" :
            (cmd == 8'h60) ? "R8" : ((cmd >= 8'h40 && cmd <= 8'h47) || cmd == 8'h50 || cmd == 8'h51) ? "R7" : "R9";
      if (mem && xerr) tag = "R6";
      send(cmd);
      if (mem) begin
        send(a1);
        send(a2);
        chk(rsp_valid_o == 1'b0, "R11 one wait cycle", rsp_valid_o, 0);
        @(negedge clk_i);
        chk(rsp_valid_o == 1'b1, "R11 first byte after wait", rsp_valid_o, 1);
      end else begin
        chk(rsp_valid_o == 1'b1, "R11 single byte next cycle", rsp_valid_o, 1);
      end
      chk(cmd_ready_o == 1'b0, "R11 busy while pending", cmd_ready_o, 0);
      for (int k = 0; k < len; k++) begin
        logic [7:0] xd;
        xd = xerr ? 8'h00 : exp_byte(cmd, a1, a2, k);
        recv(d, l, e);
        chk(d == xd, {tag, " data (R2)"}, d, xd);
        chk(l == (k == len - 1), "R10 last flag", l, (k == len - 1));
        chk(e == xerr, {tag, " err flag (R10)"}, e, xerr);
      end
      chk(cmd_ready_o == 1'b1 && rsp_valid_o == 1'b0, "R10 idle after last",
          {cmd_ready_o, rsp_valid_o}, 2'b10);
    end

    // R12: back-pressure on a program read
    dl_ready_i = 1'b1; dsp_run_i = 1'b0;
    send(8'h38); send(8'h0A); send(8'h5C);
    while (!rsp_valid_o) @(negedge clk_i);
    d0 = rsp_data_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(rsp_valid_o == 1'b1 && rsp_data_o == d0 && rsp_last_o == 1'b0, "R12 hold under stall",
          {rsp_valid_o, rsp_data_o}, {1'b1, d0});
    end
    for (int k = 0; k < 5; k++) begin
      recv(d, l, e);
      chk(d == exp_byte(8'h38, 8'h0A, 8'h5C, k), "R12 data after stall R3", d, exp_byte(8'h38, 8'h0A, 8'h5C, k));
    end

    // R1: reset in the middle of a reply
    send(8'h34); send(8'h01); send(8'h02);
    while (!rsp_valid_o) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(rsp_valid_o == 1'b0 && cmd_ready_o == 1'b1, "R1 reset mid reply",
        {cmd_ready_o, rsp_valid_o}, 2'b10);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    send(8'h60);
    recv(d, l, e);
    chk(d == 8'h19 && l == 1'b1 && e == 1'b0, "R8 id after reset", {d, l, e}, {8'h19, 2'b10});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule